// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block sends the contents of a small byte memory out on a serial data pin. It needs no command and no address: each rising edge of a slow external strobe clock (VCLK) moves the output to the next bit slot. After reset the block first counts a fixed number of strobe edges as a synchronization preamble, with the data pin released the whole time. On the following edge it starts driving the most significant bit of the byte at address zero. Each byte takes nine strobe edges: eight data bits, most significant first, then one idle slot in which the pin is released and the next byte is fetched.

The block runs on a fast system clock with a synchronous active-high reset. The strobe and the SCL level arrive already synchronized to that clock. Bytes come from an external synchronous memory through a one-cycle-latency read port. The address wraps from the top of the array back to zero. Streaming only takes place while the SCL input is high. When SCL goes low the pin is released and strobe edges are ignored. When SCL rises again, the next strobe edge resumes at the most significant bit of the current byte, without a new preamble. The pin is modelled as an output enable plus an output value.

Top module: `tos_streamer`

## Requirements
- R1: While reset is asserted, sda_oe is 0, sda_o is 1 and mem_rd is 0.
- R2: The first SYNC_PULSES (default 9) qualified VCLK rising edges after reset leave sda_oe at 0. A qualified edge is a 0-to-1 change of vclk, sampled on clk, with scl_hi at 1.
- R3: The next qualified edge drives sda_oe to 1, with sda_o equal to bit 7 of the byte at address 0.
- R4: From then on, each byte takes 9 qualified edges. The first 8 drive bits 7 down to 0 of the byte in turn. The 9th releases the pin (sda_oe 0, sda_o 1).
- R5: Successive byte reads use addresses that rise by one. After address 2^ADDR_W-1 the next read is address 0.
- R6: Exactly one mem_rd pulse, one clk wide, is issued per byte. Byte 0 is read in the first cycle after reset is released. Each later byte is read on the edge that opens the idle slot, and the read data is taken one clk later.
- R7: With scl_hi at 0, sda_oe is 0 and sda_o is 1 from the following clk on. VCLK edges are then ignored: no read, no preamble count, no slot advance.
- R8: After scl_hi returns to 1 in streaming, the next qualified edge drives bit 7 of the most recently fetched byte. No preamble is repeated.
- R9: sda_oe and sda_o change only on a clk in which a qualified edge occurs or scl_hi is 0. They are held in every other cycle.
- R10: A vclk level that is already high when reset is released is not an edge. The first edge needs vclk to be seen low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vclk | input | 1 | Synchronized strobe clock level |
| scl_hi | input | 1 | Synchronized SCL level; 1 permits streaming |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid one clk after mem_rd |
| sda_oe | output | 1 | Data pin output enable |
| sda_o | output | 1 | Data pin value; 1 whenever released |

## Verification
The properties assume that vclk and scl_hi are clean, synchronous levels. They also assume that every vclk high and low phase lasts at least two clk cycles, so that a fetched byte is in place before the next edge. They further assume that mem_rdata is valid exactly one clk after mem_rd. The bench drives both levels only on falling clk edges and holds each vclk phase for two or three cycles. Its memory model answers on the clk edge after the read strobe, so the stimulus always stays inside these assumptions.

// File: rtl/tos_pkg.sv
`timescale 1ns/1ps
package tos_pkg;

    typedef enum logic {
        PH_PREAMBLE = 1'b0,
        PH_STREAM   = 1'b1
    } tos_phase_e;

    typedef struct packed {
        logic oe;
        logic dat;
    } tos_pin_t;

    localparam tos_pin_t PIN_RELEASED = '{oe: 1'b0, dat: 1'b1};

    // number of strobe slots a byte occupies: data bits plus the idle slot
    function automatic int unsigned slots_per_byte(input int unsigned data_w);
        return data_w + 1;
    endfunction

endpackage

// File: rtl/tos_rise_det.sv
`timescale 1ns/1ps
module tos_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // reset to 1: a level already high at reset exit is not an edge
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    assign rise = lvl && !lvl_q;
endmodule

// File: rtl/tos_seq.sv
`timescale 1ns/1ps
module tos_seq
    import tos_pkg::*;
#(
    parameter  int unsigned DATA_W      = 8,
    parameter  int unsigned SYNC_PULSES = 9,
    localparam int unsigned SLOTS       = slots_per_byte(DATA_W),
    localparam int unsigned SLOT_W      = $clog2(SLOTS),
    localparam int unsigned CNT_W       = $clog2(SYNC_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              scl_hi,
    output tos_phase_e        phase,
    output logic              upd,
    output logic              nxt_drive,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic              fetch
);
    localparam logic [SLOT_W-1:0] GAP      = SLOT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SYNC_PULSES);

    tos_phase_e        phase_q, phase_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [SLOT_W-1:0] slot_q, slot_n;
    logic              drive_q, drive_n;
    logic              primed_q;
    logic              adv;
    logic              gap_fetch;

    assign adv = rise && scl_hi;

    always_comb begin
        phase_n   = phase_q;
        cnt_n     = cnt_q;
        slot_n    = slot_q;
        drive_n   = drive_q;
        upd       = 1'b0;
        gap_fetch = 1'b0;
        unique case (phase_q)
            PH_PREAMBLE: begin
                if (adv) begin
                    if (cnt_q == CNT_LAST) begin
                        phase_n = PH_STREAM;
                        drive_n = 1'b1;
                        slot_n  = '0;
                        upd     = 1'b1;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            PH_STREAM: begin
                if (!scl_hi) begin
                    drive_n = 1'b0;
                    slot_n  = '0;
                    upd     = 1'b1;
                end else if (adv) begin
                    upd = 1'b1;
                    if (!drive_q) begin
                        drive_n = 1'b1;
                        slot_n  = '0;
                    end else if (slot_q == GAP) begin
                        slot_n = '0;
                    end else begin
                        slot_n = slot_q + 1'b1;
                        if (slot_q == GAP - 1'b1) gap_fetch = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_PREAMBLE;
            cnt_q    <= '0;
            slot_q   <= '0;
            drive_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            phase_q  <= phase_n;
            cnt_q    <= cnt_n;
            slot_q   <= slot_n;
            drive_q  <= drive_n;
            primed_q <= 1'b1;
        end
    end

    assign phase     = phase_q;
    assign nxt_drive = drive_n;
    assign nxt_slot  = slot_n;
    assign fetch     = (!primed_q && !rst) || gap_fetch;
endmodule

// File: rtl/tos_fetch.sv
`timescale 1ns/1ps
module tos_fetch #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] byte_q
);
    logic [ADDR_W-1:0] ptr_q;
    logic              cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            cap_q  <= 1'b0;
            byte_q <= '1;
        end else begin
            cap_q <= fetch;
            if (fetch) ptr_q  <= ptr_q + 1'b1;   // natural wrap at 2^ADDR_W
            if (cap_q) byte_q <= mem_rdata;
        end
    end

    assign mem_rd   = fetch;
    assign mem_addr = ptr_q;
endmodule

// File: rtl/tos_pin_drv.sv
`timescale 1ns/1ps
module tos_pin_drv
    import tos_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              nxt_drive,
    input  logic [SLOT_W-1:0] nxt_slot,
    input  logic [DATA_W-1:0] byte_q,
    output tos_pin_t          pin
);
    localparam logic [SLOT_W-1:0] GAP = SLOT_W'(DATA_W);

    logic     bit_val;
    tos_pin_t nxt_pin;

    always_comb begin
        bit_val = 1'b1;
        for (int i = 0; i < int'(DATA_W); i++) begin
            if (nxt_slot == SLOT_W'(i)) bit_val = byte_q[DATA_W-1-i];
        end
        nxt_pin.oe  = nxt_drive && (nxt_slot < GAP);
        nxt_pin.dat = nxt_pin.oe ? bit_val : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      pin <= PIN_RELEASED;
        else if (upd) pin <= nxt_pin;
    end
endmodule

// File: rtl/tos_streamer.sv
`timescale 1ns/1ps
module tos_streamer
    import tos_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_PULSES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vclk,
    input  logic              scl_hi,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sda_oe,
    output logic              sda_o
);
    localparam int unsigned SLOT_W = $clog2(slots_per_byte(DATA_W));

    logic              rise;
    tos_phase_e        phase;
    logic              upd;
    logic              nxt_drive;
    logic [SLOT_W-1:0] nxt_slot;
    logic              fetch;
    logic [DATA_W-1:0] byte_q;
    tos_pin_t          pin;

    tos_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (vclk),
        .rise (rise)
    );

    tos_seq #(
        .DATA_W      (DATA_W),
        .SYNC_PULSES (SYNC_PULSES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .scl_hi    (scl_hi),
        .phase     (phase),
        .upd       (upd),
        .nxt_drive (nxt_drive),
        .nxt_slot  (nxt_slot),
        .fetch     (fetch)
    );

    tos_fetch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .fetch     (fetch),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .byte_q    (byte_q)
    );

    tos_pin_drv #(
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_pin (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .nxt_drive (nxt_drive),
        .nxt_slot  (nxt_slot),
        .byte_q    (byte_q),
        .pin       (pin)
    );

    assign sda_oe = pin.oe;
    assign sda_o  = pin.dat;
endmodule

// File: rtl/tos_streamer_chk.sv
`timescale 1ns/1ps
module tos_streamer_chk
    import tos_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              vclk,
    input logic              scl_hi,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sda_oe,
    input logic              sda_o,
    input tos_phase_e        phase
);
    logic              vclk_q;
    logic              rise_c;
    logic              have_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vclk_q <= 1'b1;
            have_q <= 1'b0;
            last_q <= '0;
        end else begin
            vclk_q <= vclk;
            if (mem_rd) begin
                have_q <= 1'b1;
                last_q <= mem_addr;
            end
        end
    end

    assign rise_c = vclk && !vclk_q;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && sda_o));

    a_r2_preamble_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PREAMBLE) |-> !sda_oe);

    a_r3_first_read_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !have_q) |-> (mem_addr == '0));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && have_q) |-> (mem_addr == ADDR_W'(last_q + 1'b1)));

    a_r6_read_single: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    a_r6_read_in_gap: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !sda_oe);

    a_r7_scl_low_release: assert property (@(posedge clk) disable iff (rst)
        !scl_hi |=> (!sda_oe && sda_o));

    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        (scl_hi && !rise_c) |=> ($stable(sda_oe) && $stable(sda_o)));
endmodule

bind tos_streamer tos_streamer_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .vclk     (vclk),
    .scl_hi   (scl_hi),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .sda_oe   (sda_oe),
    .sda_o    (sda_o),
    .phase    (phase)
);

// File: tb/tos_streamer_tb_top.sv
`timescale 1ns/1ps
module tos_streamer_tb_top;
    localparam int AW = 7;
    localparam int DW = 8;
    localparam int SP = 9;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vclk = 1'b1;
    logic          scl_hi = 1'b1;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          sda_oe;
    logic          sda_o;

    int  vecs = 0;
    int  errs = 0;
    int  rd_cnt = 0;
    int  last_rd = -1;
    bit  done = 1'b0;

    // model state
    int  m_sync, m_slot, m_cur, m_reads;
    bit  m_drive, m_first;
    logic e_oe, e_o;

    always #2 clk = ~clk;

    tos_streamer #(.ADDR_W(AW), .DATA_W(DW), .SYNC_PULSES(SP)) dut_i (
        .clk(clk), .rst(rst), .vclk(vclk), .scl_hi(scl_hi),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .sda_oe(sda_oe), .sda_o(sda_o)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 71) ^ (a >> 2));
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= pat(int'(mem_addr));
            rd_cnt    <= rd_cnt + 1;
            last_rd   <= int'(mem_addr);
        end
    end

    task automatic chk_pin(input string req);
        vecs++;
        if (sda_oe !== e_oe || sda_o !== e_o) begin
            errs++;
            $display("FAIL %s: oe/o = %b/%b expected %b/%b", req, sda_oe, sda_o, e_oe, e_o);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vclk = 1'b1; scl_hi = 1'b1;
        repeat (3) @(negedge clk);
        e_oe = 1'b0; e_o = 1'b1;
        chk_pin("R1 pin in reset");
        chk_int("R1 mem_rd in reset", int'(mem_rd), 0);
        m_reads = rd_cnt;
        m_sync = 0; m_slot = 0; m_cur = 0; m_drive = 1'b0; m_first = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        m_reads++;
        chk_int("R6 byte 0 read after reset", rd_cnt, m_reads);
        chk_int("R3 first read address", last_rd, 0);
        // R10: vclk stays high past reset exit, then falls
        repeat (2) @(negedge clk);
        chk_pin("R10 held-high vclk not an edge");
        vclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse();
        string tag;
        @(negedge clk) vclk = 1'b1;
        @(negedge clk);
        tag = "R9 hold";
        if (!scl_hi) begin
            e_oe = 1'b0; e_o = 1'b1; tag = "R7 edge ignored while SCL low";
            chk_int("R7 no read while SCL low", rd_cnt, m_reads);
        end else if (m_sync < SP) begin
            m_sync++; e_oe = 1'b0; e_o = 1'b1; tag = "R2 preamble released";
        end else if (!m_drive) begin
            m_drive = 1'b1; m_slot = 0;
            e_oe = 1'b1; e_o = pat(m_cur)[7];
            tag = m_first ? "R3 first MSB from address 0" : "R8 resume MSB";
            m_first = 1'b0;
        end else begin
            m_slot = (m_slot + 1) % (DW + 1);
            if (m_slot == DW) begin
                m_cur = (m_cur + 1) % NB;
                m_reads++;
                e_oe = 1'b0; e_o = 1'b1; tag = "R4 idle slot released";
                chk_int("R6 one read per byte", rd_cnt, m_reads);
                chk_int("R5 read address sequence", last_rd, m_cur);
            end else begin
                e_oe = 1'b1; e_o = pat(m_cur)[7 - m_slot]; tag = "R4 data bit";
            end
        end
        chk_pin(tag);
        @(negedge clk);
        chk_pin("R9 stable with vclk high");
        vclk = 1'b0;
        repeat (2) @(negedge clk);
        chk_pin("R9 stable with vclk low");
    endtask

    task automatic set_scl(input logic v);
        @(negedge clk) scl_hi = v;
        if (!v && m_sync >= SP) m_drive = 1'b0;
        @(negedge clk);
        if (!v) begin
            e_oe = 1'b0; e_o = 1'b1;
            chk_pin("R7 released after SCL low");
        end else begin
            chk_pin("R9 no change on SCL rise alone");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R4 watchdog: run still busy after %0d cycles, expected end", 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        e_oe = 1'b0; e_o = 1'b1;
        do_reset();
        // preamble plus more than a full wrap of the array
        for (int i = 0; i < SP + (NB + 2) * (DW + 1); i++) pulse();
        // interrupt in the middle of a byte
        repeat (3) pulse();
        set_scl(1'b0);
        repeat (4) pulse();
        set_scl(1'b1);
        repeat (DW + 5) pulse();
        // interrupt exactly in the idle slot
        while (m_slot != DW) pulse();
        set_scl(1'b0);
        repeat (2) pulse();
        set_scl(1'b1);
        repeat (2 * (DW + 1)) pulse();
        // second run: SCL low during the preamble stalls the count
        do_reset();
        repeat (4) pulse();
        set_scl(1'b0);
        repeat (5) pulse();
        set_scl(1'b1);
        repeat (SP - 4) pulse();
        repeat (3 * (DW + 1)) pulse();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule